// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This unit is the arithmetic, logic and shift stage of a small controller core. Each cycle it takes a destination operand, a second operand and a four-bit operation code. The second operand is either a register value or an immediate. The unit returns a 16-bit result, a register write enable, a flag write enable and four status flags: zero, negative, carry and overflow.

The unit is purely combinational. The core around it holds the register file and the flag register. It commits the result when the write enable is high and latches the flags when the flag write enable is high.

The carry and overflow rules depend on the class of the operation:
- Logic operations clear both carry and overflow.
- Shifts report the last bit shifted out as carry and clear overflow.
- Subtract and compare report an unsigned borrow as carry. A following "less than, unsigned" branch therefore tests carry alone, and "greater than, unsigned" tests carry and zero both clear.
- Overflow marks two's-complement overflow, so the signed branch conditions can combine it with the negative flag.

Top module: `flag_alu`

## Requirements
- R1: The operation code selects the operation as follows: 0 AND, 1 OR, 2 XOR, 3 TEST, 4 INVERT, 5 ADD, 6 SUB, 7 SUBR, 8 CMP, 9 ABS, 10 NEG, 11 LSL, 12 LSR, 13 ASR; codes 14 and 15 are reserved. Operand A is `dst_val`. Operand B is `imm_val` when `b_is_imm` is 1, and `src_val` otherwise.
- R2: AND, OR, XOR, TEST (A&B) and INVERT (~A) produce the bitwise result, with carry and overflow both 0.
- R3: TEST and CMP drive `wr_en` low and `flag_we` high; every other defined code drives both high.
- R4: ADD gives (A+B) mod 2^16; carry is the carry out of bit 15, and overflow is 1 when the signed sum falls outside -32768..32767.
- R5: SUB and CMP compute A-B; carry is 1 exactly when A < B as unsigned values; overflow is 1 when the signed difference falls outside the 16-bit range.
- R6: SUBR computes B-A, with carry 1 exactly when B < A unsigned and overflow marking signed overflow.
- R7: NEG computes 0-A; carry is 1 when A is nonzero; negating 0x8000 gives 0x8000 with overflow 1.
- R8: When A is zero or positive, ABS returns A with carry and overflow 0. Otherwise it behaves exactly as NEG.
- R9: LSL shifts A left by B; carry is the last bit shifted out of bit 15. A shift amount of 0 returns A with carry 0.
- R10: LSR shifts A right and fills with zeros. ASR shifts A right and fills with copies of bit 15. For both, carry is the last bit shifted out of bit 0, and a shift amount of 0 gives carry 0.
- R11: With shift amounts of 16 or more, LSL and LSR return 0 and ASR returns every bit equal to A's bit 15. Carry is the bit that the 16th shift step moved out, or 0 when the amount exceeds 16. ASR is the exception: for any amount of 16 or more its carry equals A's bit 15.
- R12: All three shifts give overflow 0.
- R13: Reserved codes give a result of 0, `wr_en` and `flag_we` low, and all four flags 0.
- R14: For every defined code, zero is 1 exactly when the 16-bit result is 0, and negative equals result bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (R1) |
| b_is_imm | input | 1 | Selects the immediate as operand B |
| dst_val | input | 16 | Operand A, the destination register value |
| src_val | input | 16 | Source register value |
| imm_val | input | 16 | Immediate value |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Destination write enable |
| flag_we | output | 1 | Flag register update enable |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow / shifted-out flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Every output is a combinational function of the current inputs, so all results are due in the same cycle the stimulus is applied; no register lies on any path. The bench applies each stimulus on the falling clock edge and samples one nanosecond later, well before the next rising edge. The expected value comes from an integer-arithmetic model in the bench that shifts one bit per step. The sweep crosses all sixteen codes with a grid of boundary operands (0, 1, 0x7FFF, 0x8000, 0x8001, 0xFFFF and others) and shift amounts 0 to 18, then adds pseudo-random pairs. The source of operand B alternates between the source register and the immediate, and the unused one is loaded with a decoy value.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_TST  = 4'd3,
        OP_INV  = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_SUBR = 4'd7,
        OP_CMP  = 4'd8,
        OP_ABS  = 4'd9,
        OP_NEG  = 4'd10,
        OP_LSL  = 4'd11,
        OP_LSR  = 4'd12,
        OP_ASR  = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import flag_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   r
);
    always_comb begin
        unique case (op)
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_INV:  r = ~a;
            default: r = a & b;   // AND and TEST
        endcase
    end
endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit #(
    parameter int W = 16
) (
    input  logic           sub,
    input  logic [W-1:0]   p,
    input  logic [W-1:0]   q,
    output logic [W-1:0]   r,
    output logic           c,
    output logic           v
);
    logic [W:0]   sum;
    logic [W-1:0] q_eff;

    always_comb begin
        q_eff = sub ? ~q : q;
        sum   = {1'b0, p} + {1'b0, q_eff} + {{W{1'b0}}, sub};
        r     = sum[W-1:0];
        // subtract: no carry out of the top means a borrow occurred
        c     = sub ? ~sum[W] : sum[W];
        v     = (p[W-1] == q_eff[W-1]) && (r[W-1] != p[W-1]);
    end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import flag_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  shift_kind_e    kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   amt,
    output logic [W-1:0]   r,
    output logic           c
);
    localparam int AW = $clog2(W + 2);

    logic [AW-1:0]      sh;
    logic [W:0]         ext_l;
    logic [W:0]         ext_r;
    logic signed [W:0]  ext_a;

    always_comb begin
        // anything beyond W+1 behaves like W+1: every bit is gone
        sh    = (amt > W) ? AW'(W + 1) : AW'(amt);
        ext_l = {1'b0, a} << sh;
        ext_r = {a, 1'b0} >> sh;
        ext_a = $signed({a, 1'b0}) >>> sh;
        unique case (kind)
            SH_RIGHT: begin r = ext_r[W:1]; c = ext_r[0]; end
            SH_ARITH: begin r = ext_a[W:1]; c = ext_a[0]; end
            default:  begin r = ext_l[W-1:0]; c = ext_l[W]; end
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]     op,
    input  logic           b_is_imm,
    input  logic [W-1:0]   dst_val,
    input  logic [W-1:0]   src_val,
    input  logic [W-1:0]   imm_val,
    output logic [W-1:0]   result,
    output logic           wr_en,
    output logic           flag_we,
    output logic           flag_z,
    output logic           flag_n,
    output logic           flag_c,
    output logic           flag_v
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    alu_op_e      op_e;
    logic [W-1:0] opnd_b;
    logic [W-1:0] log_r;
    logic [W-1:0] as_p, as_q, as_r;
    logic         as_sub, as_c, as_v;
    logic [W-1:0] sh_r;
    logic         sh_c;
    shift_kind_e  sh_kind;

    assign op_e   = alu_op_e'(op);
    assign opnd_b = b_is_imm ? imm_val : src_val;

    alu_logic_unit #(.W(W)) u_logic (
        .op (op_e), .a (dst_val), .b (opnd_b), .r (log_r)
    );

    always_comb begin
        as_sub = 1'b1;
        as_p   = dst_val;
        as_q   = opnd_b;
        unique case (op_e)
            OP_ADD:  as_sub = 1'b0;
            OP_SUBR: begin as_p = opnd_b; as_q = dst_val; end
            OP_NEG:  begin as_p = '0; as_q = dst_val; end
            OP_ABS:  begin
                if (dst_val[W-1]) begin as_p = '0; as_q = dst_val; end
                else              begin as_p = dst_val; as_q = '0; end
            end
            default: ;
        endcase
    end

    alu_addsub_unit #(.W(W)) u_addsub (
        .sub (as_sub), .p (as_p), .q (as_q), .r (as_r), .c (as_c), .v (as_v)
    );

    always_comb begin
        unique case (op_e)
            OP_LSR:  sh_kind = SH_RIGHT;
            OP_ASR:  sh_kind = SH_ARITH;
            default: sh_kind = SH_LEFT;
        endcase
    end

    alu_shift_unit #(.W(W)) u_shift (
        .kind (sh_kind), .a (dst_val), .amt (opnd_b), .r (sh_r), .c (sh_c)
    );

    always_comb begin
        result  = '0;
        wr_en   = 1'b1;
        flag_we = 1'b1;
        flag_c  = 1'b0;
        flag_v  = 1'b0;
        unique case (op_e)
            OP_AND, OP_OR, OP_XOR, OP_INV: result = log_r;
            OP_TST: begin result = log_r; wr_en = 1'b0; end
            OP_ADD, OP_SUB, OP_SUBR, OP_ABS, OP_NEG: begin
                result = as_r; flag_c = as_c; flag_v = as_v;
            end
            OP_CMP: begin
                result = as_r; flag_c = as_c; flag_v = as_v; wr_en = 1'b0;
            end
            OP_LSL, OP_LSR, OP_ASR: begin result = sh_r; flag_c = sh_c; end
            default: begin wr_en = 1'b0; flag_we = 1'b0; end
        endcase
        flag_z = flag_we && (result == '0);
        flag_n = flag_we && result[W-1];
    end

    always_comb begin
        if (op_e inside {OP_AND, OP_OR, OP_XOR, OP_TST, OP_INV})
            AST_LOGIC_CLEARS_CV: assert (!flag_c && !flag_v);   // R2
        if (op_e inside {OP_TST, OP_CMP})
            AST_TEST_NO_WRITE: assert (!wr_en && flag_we);      // R3
        if (op_e inside {OP_SUB, OP_CMP})
            AST_SUB_BORROW: assert (flag_c == (dst_val < opnd_b)); // R5
        if (op_e == OP_NEG && dst_val == MIN_NEG)
            AST_NEG_MIN_OVERFLOW: assert (result == MIN_NEG && flag_v); // R7
        if (op_e inside {OP_LSL, OP_LSR, OP_ASR})
            AST_SHIFT_NO_OVERFLOW: assert (!flag_v);            // R12
        if (op_e inside {OP_RS14, OP_RS15})
            AST_RESERVED_IDLE: assert (!wr_en && !flag_we && !flag_z && !flag_c); // R13
    end
endmodule

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic        b_is_imm = 1'b0;
    logic [15:0] dst_val = '0, src_val = '0, imm_val = '0;
    logic [15:0] result;
    logic        wr_en, flag_we, flag_z, flag_n, flag_c, flag_v;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    flag_alu u0 (
        .op(op), .b_is_imm(b_is_imm), .dst_val(dst_val), .src_val(src_val),
        .imm_val(imm_val), .result(result), .wr_en(wr_en), .flag_we(flag_we),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic int sgn(int x);
        return (x >= 32768) ? x - 65536 : x;
    endfunction

    // expected {result, wr_en, flag_we, z, n, c, v}
    function automatic logic [21:0] model(int code, int a, int b);
        int r = 0, c = 0, v = 0, sr = 0, steps;
        bit wr = 1, fwe = 1, z, n;
        case (code)
            0: r = a & b;
            1: r = a | b;
            2: r = a ^ b;
            3: begin r = a & b; wr = 0; end
            4: r = (~a) & 65535;
            5: begin r = a + b; c = (r > 65535); sr = sgn(a) + sgn(b); end
            6, 8: begin r = a - b; c = (a < b); sr = sgn(a) - sgn(b); wr = (code == 6); end
            7: begin r = b - a; c = (b < a); sr = sgn(b) - sgn(a); end
            9: begin
                if (sgn(a) < 0) begin r = -a; c = 1; sr = -sgn(a); end
                else r = a;
            end
            10: begin r = -a; c = (a != 0); sr = -sgn(a); end
            11, 12, 13: begin
                r = a;
                steps = (b > 20) ? 20 : b;
                for (int k = 0; k < steps; k++) begin
                    if (code == 11) begin c = (r >> 15) & 1; r = (r << 1) & 65535; end
                    else if (code == 12) begin c = r & 1; r = r >> 1; end
                    else begin c = r & 1; r = (r >> 1) | (r & 32768); end
                end
            end
            default: begin r = 0; wr = 0; fwe = 0; end
        endcase
        if (code >= 5 && code <= 10) v = (sr > 32767 || sr < -32768);
        r = r & 65535;
        z = fwe && (r == 0);
        n = fwe && ((r >> 15) & 1);
        return {r[15:0], wr, fwe, z, n, c[0], v[0]};
    endfunction

    function automatic string tag(int code);
        case (code)
            0, 1, 2, 4: return "R1 R14 R2";
            3:          return "R1 R14 R2 R3";
            5:          return "R1 R14 R4";
            6:          return "R1 R14 R5";
            8:          return "R1 R14 R3 R5";
            7:          return "R1 R14 R6";
            9:          return "R1 R14 R8";
            10:         return "R1 R14 R7";
            11:         return "R1 R14 R9 R11 R12";
            12, 13:     return "R1 R14 R10 R11 R12";
            default:    return "R1 R13";
        endcase
    endfunction

    function automatic int corner(int i);
        case (i)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF;
            3: return 16'h8000; 4: return 16'h8001; 5: return 16'hFFFF;
            6: return 16'h00FF; default: return 16'hA5C3;
        endcase
    endfunction

    task automatic run(int code, int a, int b, bit use_imm);
        logic [21:0] exp_v, got;
        @(negedge clk);
        op       = code[3:0];
        dst_val  = a[15:0];
        b_is_imm = use_imm;
        if (use_imm) begin imm_val = b[15:0]; src_val = ~b[15:0]; end
        else         begin src_val = b[15:0]; imm_val = ~b[15:0]; end
        #1;
        exp_v = model(code, a, b);
        got   = {result, wr_en, flag_we, flag_z, flag_n, flag_c, flag_v};
        tests++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%0b got=%h exp=%h",
                     tag(code), code, a[15:0], b[15:0], use_imm, got, exp_v);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1357;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state check: idle inputs give AND of zeros (R2, R14)
        run(0, 0, 0, 0);
        for (int code = 0; code < 16; code++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++)
                    run(code, corner(i), corner(j), (i + j) % 2 == 1);
                for (int s = 0; s <= 18; s++)
                    run(code, corner(i), s, s % 2 == 0);
                run(code, corner(i), 16'hFFFF, 1);
            end
            for (int k = 0; k < 200; k++) begin
                int a, b;
                seed = seed * 1103515245 + 12345;
                a = (seed >>> 8) & 65535;
                seed = seed * 1103515245 + 12345;
                b = (seed >>> 8) & 65535;
                if (code >= 11 && code <= 13) b = b % 24;
                run(code, a, b, k % 2 == 0);
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule